// File: doc/BRIEF.md
# Interlaced Video Frame Capture Writer

This block sits behind a video decoder's 8-bit digital pixel port and turns the byte stream into frame-buffer writes for a 16-bit external SRAM. It watches the stream for the embedded timing codes that mark where each line's active samples start and end. The same codes tell it which of the two interlaced fields is arriving. Every Cb-Y-Cr-Y sample group inside the active area becomes one 16-bit word. The word's address is built from the display row and from the pixel index with its low bit dropped. Lines of the first field land on even rows and lines of the second field on odd rows, so memory holds one woven frame.

Two pushbutton pulses control capture. A start press arms capture and a stop press disarms it. Either request takes effect only at the next frame boundary, so a stopped capture always leaves the last whole frame in memory. A mode pin selects the word format. The wide-colour format keeps one colour per pixel pair. The luma-only format keeps the two luma samples, one in each byte.

Writes leave on a valid/ready stream toward a RAM controller. The decoder side cannot be stalled. For that reason the input has a valid strobe and no ready, and at most two words can wait on the output. A word that arrives while both are waiting is dropped, and a sticky flag records the loss.

Top module: `vid_fcap_top`

## Requirements
- R1: A timing code is the four valid bytes 0xFF, 0x00, 0x00, XY, where XY bit 6 is the field bit F, bit 5 the vertical-blank bit V and bit 4 the H bit. H=0 means start of active video and H=1 means end of active video. The XY byte is never stored as a sample, and sample bytes that only partly look like a code are still stored as samples.
- R2: Each write address is {row[9:0], group[8:0]} (19 bits). The group is the pixel index divided by two, that is, the count of complete sample groups since the start-of-active code.
- R3: The row is 2 × line + F, where line counts active lines within the current field. The line count returns to 0 on a code with V=1 whose F differs from the previous code's F. It rises by one at each end-of-active code that closes a line opened by a start-of-active code with V=0.
- R4: When narrow_mode is 0, each group Cb, Y0, Cr, Y1 gives exactly one word: {Y0[7:2], Cb[7:3], Cr[7:3]}.
- R5: When narrow_mode is 1, each group gives exactly one word {Y0, Y1}: pixel 0 in the upper byte and pixel 1 in the lower byte.
- R6: Only groups 0 to ACTIVE_PIX/2−1 of a line, and lines 0 to FIELD_LINES−1 of a field, are written. Start-of-active codes with V=1 open no line.
- R7: A frame boundary is a code with V=1 and F=0 that follows a code with F=1. A pending start sets `capturing` at the boundary and a pending stop clears it there. A later press replaces an earlier pending one, and stop wins if both buttons are pressed in the same cycle. No write is made while `capturing` is 0.
- R8: A word appears on the output one cycle after its last sample byte is accepted. `wr_valid` then stays high with `wr_addr` and `wr_data` stable until `wr_ready` is sampled high. Words leave in the order they were formed.
- R9: At most two words can wait, one on the output and one held behind it. A word formed while both are waiting and no transfer happens is dropped and sets `overflow`. The flag stays set until a start press.
- R10: After reset, `wr_valid`, `capturing` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | A video byte is present this cycle (cannot be stalled) |
| vid_byte | input | 8 | Video byte from the decoder pixel port |
| narrow_mode | input | 1 | 1 selects the two-luma word format, 0 the colour format |
| start_btn | input | 1 | One-cycle start request |
| stop_btn | input | 1 | One-cycle stop request |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | RAM controller takes the word this cycle |
| wr_addr | output | ROW_W+GRP_W (19) | Word address {row, group} |
| wr_data | output | 16 | Word data |
| capturing | output | 1 | Frames are being written |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
Lines are sent longer than the active width and fields taller than the active height, so that a design with no bound writes outside the frame or wraps its addresses. A stop press in the middle of a frame must still let the second field through and must then block the next frame. A design that stopped mid-frame, or that ignored the boundary, would show a wrong write count. Data lines that carry 0xFF, 0x00 fragments check that a partial code neither eats samples nor shifts the group phase; a design that got this wrong would lose or misalign whole lines. Long ready stalls fill both slots. They check that only the word arriving while both are full is lost, that the flag stays set, and that a start press clears it.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  // Bit positions of the flags inside the fourth byte of a timing code.
  localparam int XY_F_BIT = 6;
  localparam int XY_V_BIT = 5;
  localparam int XY_H_BIT = 4;
  localparam logic [7:0] PRE_HI = 8'hFF;
  localparam logic [7:0] PRE_LO = 8'h00;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_t;

  // Pack one Cb/Y0/Cr/Y1 group into one memory word.
  function automatic logic [15:0] pack_word(input logic       narrow,
                                            input logic [4:0] cb_hi,
                                            input logic [7:0] y0,
                                            input logic [4:0] cr_hi,
                                            input logic [7:0] y1);
    return narrow ? {y0, y1} : {y0[7:2], cb_hi, cr_hi};
  endfunction
endpackage

// File: rtl/vfc_trs_parse.sv
module vfc_trs_parse
  import vfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       code_stb,
  output trs_t       code,
  output logic       smp_stb
);
  typedef enum logic [1:0] {P_NONE, P_FF, P_FF00, P_FF0000} pre_e;
  pre_e pre_q, pre_d;

  assign code_stb = in_valid && (pre_q == P_FF0000);
  assign smp_stb  = in_valid && (pre_q != P_FF0000);
  assign code     = '{f: in_byte[XY_F_BIT], v: in_byte[XY_V_BIT], h: in_byte[XY_H_BIT]};

  always_comb begin
    pre_d = pre_q;
    if (in_valid) begin
      if (pre_q == P_FF0000)                      pre_d = P_NONE;
      else if (in_byte == PRE_HI)                 pre_d = P_FF;
      else if (pre_q == P_FF && in_byte == PRE_LO)   pre_d = P_FF00;
      else if (pre_q == P_FF00 && in_byte == PRE_LO) pre_d = P_FF0000;
      else                                        pre_d = P_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= P_NONE;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/vfc_line_pack.sv
module vfc_line_pack
  import vfc_pkg::*;
#(
  parameter int GROUPS      = 360,
  parameter int FIELD_LINES = 288,
  parameter int ROW_W       = 10,
  parameter int GRP_W       = 9,
  localparam int LIN_W      = ROW_W - 1,
  localparam int ADDR_W     = ROW_W + GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_stb,
  input  trs_t              code,
  input  logic              smp_stb,
  input  logic [7:0]        smp_byte,
  input  logic              narrow,
  input  logic              start_btn,
  input  logic              stop_btn,
  output logic              capturing,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic [15:0]       push_data
);
  localparam logic [GRP_W-1:0] GRP_LIM = GRP_W'(GROUPS);
  localparam logic [LIN_W-1:0] LIN_LIM = LIN_W'(FIELD_LINES);

  logic             open_q, fld_q, last_f_q, cap_q, start_p_q, stop_p_q;
  logic [1:0]       phase_q;
  logic [GRP_W-1:0] grp_q;
  logic [LIN_W-1:0] line_q;
  logic [4:0]       cb_q, cr_q;
  logic [7:0]       y0_q;
  logic             fld_chg, frame_b;

  assign fld_chg   = code_stb && code.v && (code.f != last_f_q);
  assign frame_b   = fld_chg && !code.f;
  assign capturing = cap_q;

  assign push = smp_stb && open_q && (phase_q == 2'd3) && cap_q &&
                (grp_q < GRP_LIM) && (line_q < LIN_LIM);
  assign push_addr = {line_q, fld_q, grp_q};
  assign push_data = pack_word(narrow, cb_q, y0_q, cr_q, smp_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0; fld_q <= 1'b0; last_f_q <= 1'b0; cap_q <= 1'b0;
      start_p_q <= 1'b0; stop_p_q <= 1'b0; phase_q <= '0; grp_q <= '0;
      line_q <= '0; cb_q <= '0; cr_q <= '0; y0_q <= '0;
    end else begin
      if (smp_stb && open_q) begin
        phase_q <= phase_q + 2'd1;
        case (phase_q)
          2'd0:    cb_q <= smp_byte[7:3];
          2'd1:    y0_q <= smp_byte;
          2'd2:    cr_q <= smp_byte[7:3];
          default: if (grp_q != GRP_LIM) grp_q <= grp_q + 1'b1;
        endcase
      end
      if (code_stb) begin
        last_f_q <= code.f;
        if (!code.h && !code.v) begin
          open_q  <= 1'b1;
          phase_q <= '0;
          grp_q   <= '0;
          fld_q   <= code.f;
        end
        if (code.h) open_q <= 1'b0;
        if (code.h && open_q && line_q != LIN_LIM) line_q <= line_q + 1'b1;
        if (fld_chg) line_q <= '0;
        if (frame_b) begin
          if (stop_p_q)       cap_q <= 1'b0;
          else if (start_p_q) cap_q <= 1'b1;
          start_p_q <= 1'b0;
          stop_p_q  <= 1'b0;
        end
      end
      if (stop_btn) begin
        stop_p_q  <= 1'b1;
        start_p_q <= 1'b0;
      end else if (start_btn) begin
        start_p_q <= 1'b1;
        stop_p_q  <= 1'b0;
      end
    end
  end

  // R7: capture state only moves on a frame boundary
  p_cap_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != $past(cap_q)) |-> $past(frame_b));
endmodule

// File: rtl/vfc_wr_skid.sv
module vfc_wr_skid #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          ovf_clr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          overflow
);
  logic          hold_v;
  logic [AW-1:0] hold_a;
  logic [DW-1:0] hold_d;
  logic          pop, drop;

  assign pop  = wr_valid && wr_ready;
  assign drop = push && wr_valid && hold_v && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0; hold_v <= 1'b0; overflow <= 1'b0;
      wr_addr <= '0; wr_data <= '0; hold_a <= '0; hold_d <= '0;
    end else begin
      if (pop) begin
        if (hold_v) begin
          wr_addr <= hold_a;
          wr_data <= hold_d;
          hold_v  <= push;
          if (push) begin
            hold_a <= push_addr;
            hold_d <= push_data;
          end
        end else if (push) begin
          wr_addr <= push_addr;
          wr_data <= push_data;
        end else begin
          wr_valid <= 1'b0;
        end
      end else if (!wr_valid) begin
        if (push) begin
          wr_valid <= 1'b1;
          wr_addr  <= push_addr;
          wr_data  <= push_data;
        end
      end else if (!hold_v && push) begin
        hold_v <= 1'b1;
        hold_a <= push_addr;
        hold_d <= push_data;
      end
      if (drop)         overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
    end
  end

  // R8: an offered word holds still until taken
  p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R9: the loss flag only leaves on a clear request
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);
  // R9: a loss needs both slots full and no transfer
  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_valid && hold_v && !wr_ready));
endmodule

// File: rtl/vid_fcap_top.sv
module vid_fcap_top
  import vfc_pkg::*;
#(
  parameter int ACTIVE_PIX  = 720,
  parameter int FIELD_LINES = 288,
  parameter int ROW_W       = 10,
  parameter int GRP_W       = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vid_valid,
  input  logic [7:0]             vid_byte,
  input  logic                   narrow_mode,
  input  logic                   start_btn,
  input  logic                   stop_btn,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [ROW_W+GRP_W-1:0] wr_addr,
  output logic [15:0]            wr_data,
  output logic                   capturing,
  output logic                   overflow
);
  localparam int GROUPS = ACTIVE_PIX / 2;
  localparam int ADDR_W = ROW_W + GRP_W;
  localparam int WORD_W = 16;

  logic              code_stb, smp_stb, push;
  trs_t              code;
  logic [ADDR_W-1:0] push_addr;
  logic [WORD_W-1:0] push_data;

  vfc_trs_parse u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(vid_valid), .in_byte(vid_byte),
    .code_stb(code_stb), .code(code), .smp_stb(smp_stb)
  );

  vfc_line_pack #(
    .GROUPS(GROUPS), .FIELD_LINES(FIELD_LINES), .ROW_W(ROW_W), .GRP_W(GRP_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .code_stb(code_stb), .code(code),
    .smp_stb(smp_stb), .smp_byte(vid_byte), .narrow(narrow_mode),
    .start_btn(start_btn), .stop_btn(stop_btn), .capturing(capturing),
    .push(push), .push_addr(push_addr), .push_data(push_data)
  );

  vfc_wr_skid #(.AW(ADDR_W), .DW(WORD_W)) u_skid (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
    .push_data(push_data), .ovf_clr(start_btn), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .overflow(overflow)
  );

  // R1: the flag byte of a timing code never forms a word
  p_code_no_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    code_stb |-> !push);
endmodule

// File: tb/vid_fcap_top_tb_top.sv
`timescale 1ns/1ps
module vid_fcap_top_tb_top;
  localparam int AP = 16, FL = 4, RW = 10, GW = 9;
  localparam int G = AP / 2, AW = RW + GW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, vid_valid = 1'b0, narrow_mode = 1'b0;
  logic start_btn = 1'b0, stop_btn = 1'b0, wr_ready = 1'b1;
  logic [7:0] vid_byte = 8'h0;
  logic wr_valid, capturing, overflow;
  logic [AW-1:0] wr_addr;
  logic [15:0] wr_data;

  vid_fcap_top #(.ACTIVE_PIX(AP), .FIELD_LINES(FL), .ROW_W(RW), .GRP_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_byte(vid_byte),
    .narrow_mode(narrow_mode), .start_btn(start_btn), .stop_btn(stop_btn),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .capturing(capturing), .overflow(overflow)
  );

  int checks = 0, failures = 0, cyc = 0, rdy_mode = 0, seed = 0;
  int n_fire = 0, n_odd = 0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pre = 0, m_lastf = 0, m_open = 0, m_pos = 0, m_line = 0, m_fld = 0;
  int m_cap = 0, m_stt = 0, m_stp = 0, m_ovf = 0;
  logic [4:0] m_cb = '0, m_cr = '0;
  logic [7:0] m_y0 = '0;
  logic [AW-1:0] qa[$];
  logic [15:0]   qd[$];

  always @(posedge clk) begin
    if (rst_n) begin
      bit f, v, h, pw;
      logic [AW-1:0] na;
      logic [15:0] nd;
      pw = 0; na = '0; nd = '0;
      if (wr_valid && wr_ready) begin
        if (n_fire == 0) first_addr = wr_addr;
        last_addr = wr_addr;
        n_fire++;
        if (wr_addr[GW]) n_odd++;
      end
      if (qa.size() > 0 && wr_ready) begin
        void'(qa.pop_front());
        void'(qd.pop_front());
      end
      if (vid_valid) begin
        if (m_pre == 3) begin
          f = vid_byte[6]; v = vid_byte[5]; h = vid_byte[4];
          if (!h && !v) begin m_open = 1; m_pos = 0; m_fld = f; end
          if (h) begin
            if (m_open == 1 && m_line < FL) m_line++;
            m_open = 0;
          end
          if (v && int'(f) != m_lastf) begin
            m_line = 0;
            if (!f) begin
              if (m_stp == 1) m_cap = 0;
              else if (m_stt == 1) m_cap = 1;
              m_stt = 0; m_stp = 0;
            end
          end
          m_lastf = int'(f);
          m_pre = 0;
        end else begin
          if (m_open == 1) begin
            case (m_pos % 4)
              0: m_cb = vid_byte[7:3];
              1: m_y0 = vid_byte;
              2: m_cr = vid_byte[7:3];
              default: begin
                if (m_cap == 1 && (m_pos / 4) < G && m_line < FL) begin
                  pw = 1;
                  na = {9'(m_line), 1'(m_fld), 9'(m_pos / 4)};
                  nd = narrow_mode ? {m_y0, vid_byte} : {m_y0[7:2], m_cb, m_cr};
                end
              end
            endcase
            m_pos++;
          end
          if (vid_byte == 8'hFF) m_pre = 1;
          else if (m_pre == 1 && vid_byte == 8'h00) m_pre = 2;
          else if (m_pre == 2 && vid_byte == 8'h00) m_pre = 3;
          else m_pre = 0;
        end
      end
      if (start_btn) m_ovf = 0;
      if (pw) begin
        if (qa.size() < 2) begin qa.push_back(na); qd.push_back(nd); end
        else m_ovf = 1;
      end
      if (stop_btn) begin m_stp = 1; m_stt = 0; end
      else if (start_btn) begin m_stt = 1; m_stp = 0; end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", "wr_valid", longint'(wr_valid), longint'(qa.size() > 0));
      if (wr_valid && qa.size() > 0) begin
        check("R2", "wr_addr", longint'(wr_addr), longint'(qa[0]));
        if (narrow_mode) check("R5", "wr_data", longint'(wr_data), longint'(qd[0]));
        else             check("R4", "wr_data", longint'(wr_data), longint'(qd[0]));
      end
      check("R9", "overflow", longint'(overflow), longint'(m_ovf));
      check("R7", "capturing", longint'(capturing), longint'(m_cap));
    end
  end

  // ready pattern
  always @(negedge clk) begin
    case (rdy_mode)
      1:       wr_ready = cyc[0];
      2:       wr_ready = (cyc % 16) >= 12;
      default: wr_ready = 1'b1;
    endcase
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [7:0] b);
    @(negedge clk);
    vid_valid = 1'b1; vid_byte = b; start_btn = 1'b0; stop_btn = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      vid_valid = 1'b0; start_btn = 1'b0; stop_btn = 1'b0;
    end
  endtask

  task automatic press(input bit is_stop);
    @(negedge clk);
    vid_valid = 1'b0; start_btn = !is_stop; stop_btn = is_stop;
  endtask

  task automatic send_code(input bit f, input bit v, input bit h);
    put(8'hFF); put(8'h00); put(8'h00);
    put({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h});
  endtask

  task automatic filler(input int n);
    for (int i = 0; i < n; i++) put((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  task automatic send_field(input bit f, input int nl, input int ng, input bit fake);
    for (int b = 0; b < 2; b++) begin
      send_code(f, 1'b1, 1'b1); filler(4); send_code(f, 1'b1, 1'b0); filler(8);
    end
    for (int l = 0; l < nl; l++) begin
      send_code(f, 1'b0, 1'b0);
      for (int s = 0; s < ng * 4; s++) begin
        if (fake && l == 0 && s == 4)      put(8'hFF);
        else if (fake && l == 0 && s == 5) put(8'h00);
        else if (fake && l == 0 && s == 6) put(8'h55);
        else begin
          put(8'((seed * 37 + 11) % 253 + 1));
          seed++;
        end
        if (s % 7 == 6) gap(1);
      end
      send_code(f, 1'b0, 1'b1); filler(4);
    end
  endtask

  task automatic send_frame(input bit fake);
    send_field(1'b0, 5, 10, fake);
    send_field(1'b1, 5, 10, fake);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "reset wr_valid", longint'(wr_valid), 0);
    check("R10", "reset capturing", longint'(capturing), 0);
    check("R10", "reset overflow", longint'(overflow), 0);

    // idle frame: nothing written
    send_frame(1'b0); gap(40);
    check("R7", "writes while idle", n_fire, 0);

    // start, then one full frame in colour mode
    press(1'b0);
    n_fire = 0; n_odd = 0;
    send_frame(1'b0); gap(40);
    check("R6", "writes per clipped frame", n_fire, 2 * FL * G);
    check("R3", "odd-row writes", n_odd, FL * G);
    check("R2", "first address", longint'(first_addr), 0);
    check("R2", "last address", longint'(last_addr), ((2 * (FL - 1) + 1) << GW) | (G - 1));

    // two-luma mode, with partial code bytes inside the data
    narrow_mode = 1'b1;
    n_fire = 0;
    send_frame(1'b1); gap(40);
    check("R1", "writes with code-like data", n_fire, 2 * FL * G);
    check("R5", "writes in narrow mode", n_fire, 2 * FL * G);
    narrow_mode = 1'b0;

    // stop in the middle of a frame: the frame completes
    n_fire = 0;
    send_field(1'b0, 5, 10, 1'b0);
    press(1'b1);
    send_field(1'b1, 5, 10, 1'b0); gap(40);
    check("R7", "frame finished after stop", n_fire, 2 * FL * G);
    check("R7", "still capturing before boundary", longint'(capturing), 1);
    n_fire = 0;
    send_frame(1'b0); gap(40);
    check("R7", "no writes after stop", n_fire, 0);
    check("R7", "capturing after stop", longint'(capturing), 0);

    // moderate back-pressure: nothing lost
    rdy_mode = 1;
    press(1'b0);
    n_fire = 0;
    send_frame(1'b0); gap(60);
    check("R8", "writes with half-rate ready", n_fire, 2 * FL * G);
    check("R9", "no loss at half rate", longint'(overflow), 0);

    // heavy back-pressure: words dropped, flag sticks
    rdy_mode = 2;
    n_fire = 0;
    send_frame(1'b0); gap(60);
    check("R9", "overflow after long stalls", longint'(overflow), 1);
    check("R9", "some words lost", longint'(n_fire < 2 * FL * G), 1);
    rdy_mode = 0;
    gap(20);
    check("R9", "overflow still set", longint'(overflow), 1);
    press(1'b0);
    gap(2);
    check("R9", "overflow cleared by start", longint'(overflow), 0);

    gap(10);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule